// File: doc/BRIEF.md
# Modem Handshake Control and Status with Loopback

This block owns the modem handshake side of a serial port. A control register, written by the host, drives four outgoing handshake lines (terminal ready, request to send, and two general-purpose outputs, one of which also acts as the interrupt gate) and holds a loopback switch. A status word reports the current levels of the four incoming handshake lines (clear to send, data set ready, ring indicate, carrier detect). Each incoming line also has a sticky change flag. The flags stay set until the host reads the status word. While any change flag is set, the block can raise a modem-status interrupt request.

External incoming lines pass through a synchronizer of `SYNC_STAGES` flops before they are compared and latched. When loopback is on, the block ignores the external lines. The low four control bits then feed the status inputs directly, and the serial transmit stream is routed to the receive input. The transmit pin is parked at mark and the outgoing handshake lines are driven inactive. There is no streaming data path: every pin is a plain level or a one-cycle strobe, so the block has no back-pressure rules.

Top module: `mdm_loop_ctl`

## Requirements
- R1: After reset the control readback is 0x00. A write on `ctrl_wr` stores `ctrl_wdata[4:0]`, and the new value is visible on `ctrl_rdata` from the next clock. Bits 7:5 always read 0. Field positions: bit0 terminal ready, bit1 request to send, bit2 general output 1, bit3 general output 2, bit4 loopback.
- R2: With loopback off, `line_dtr`, `line_rts`, `line_out1` and `line_out2` equal control bits 0, 1, 2 and 3.
- R3: Status layout: bit4 clear to send, bit5 data set ready, bit6 ring indicate, bit7 carrier detect, and bits 0..3 are the change flags for those same lines in that order. A change on an external line is visible in the status word SYNC_STAGES+1 clocks later.
- R4: A change flag for clear to send, data set ready or carrier detect is set by any level change. Once set, it stays set until a status read.
- R5: The ring-indicate change flag (bit2) is set only by a 1-to-0 transition of that line. A 0-to-1 transition leaves it clear.
- R6: `stat_rd` high for one cycle clears all four change flags at the closing clock edge. `stat_rdata` during that cycle shows the value from before the clear.
- R7: A line change that reaches the comparator in the read cycle sets its flag again at the same edge, so the flag reads 1 afterwards.
- R8: In loopback, the status levels of clear to send, data set ready, ring indicate and carrier detect take control bits 0, 1, 2 and 3 one clock after the control register updates. External lines have no effect.
- R9: In loopback, `ser_rx_out` follows `ser_tx_in`, `pin_txd` is 1 and the four outgoing handshake lines are 0. Outside loopback, `pin_txd` follows `ser_tx_in` and `ser_rx_out` follows `pin_rxd`.
- R10: `irq_modem` is high exactly when `msi_en` is 1, control bit3 is 1 and at least one change flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data |
| ctrl_rdata | output | 8 | Control register readback |
| stat_rd | input | 1 | Status read strobe; clears change flags |
| stat_rdata | output | 8 | Status word |
| msi_en | input | 1 | Modem-status interrupt enable |
| line_cts | input | 1 | External clear to send |
| line_dsr | input | 1 | External data set ready |
| line_ri | input | 1 | External ring indicate |
| line_dcd | input | 1 | External carrier detect |
| line_dtr | output | 1 | Outgoing terminal ready |
| line_rts | output | 1 | Outgoing request to send |
| line_out1 | output | 1 | General-purpose output 1 |
| line_out2 | output | 1 | General-purpose output 2 |
| ser_tx_in | input | 1 | Serial stream from the transmitter |
| ser_rx_out | output | 1 | Serial stream to the receiver |
| pin_txd | output | 1 | External transmit pin |
| pin_rxd | input | 1 | External receive pin |
| irq_modem | output | 1 | Modem-status interrupt request |

## Verification
Control readback and the handshake outputs are due one clock after the write edge. With the default two-stage synchronizer, a change on an external line is due in the status word three clocks after it is driven. A loopback-sourced change is due two clocks after the write is driven: one clock for the control register and one for the status latch. The serial and pin routing and the interrupt request are combinational and are checked in the same cycle. Stimulus is applied on falling edges, and checks are taken after exactly the stated number of falling edges. The change-during-read case is timed so that its comparator input changes in the read cycle itself.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int LINES   = 4;
  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RI  = 2;
  localparam int IDX_DCD = 3;

  typedef logic [LINES-1:0] mdm_lines_t;

  typedef struct packed {
    logic loop;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } mdm_ctrl_t;
endpackage

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
  import mdm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr,
  input  logic [7:0] wdata,
  output mdm_ctrl_t ctrl_q,
  output logic [7:0] rdata
);
  localparam int CW = $bits(mdm_ctrl_t);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctrl_q <= '0;
    else if (wr) ctrl_q <= mdm_ctrl_t'(wdata[CW-1:0]);
  end

  assign rdata = {{(8-CW){1'b0}}, ctrl_q};

  assert_ctrl_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> rdata == $past(wdata & 8'h1F));
endmodule

// File: rtl/mdm_line_sync.sv
module mdm_line_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else if (s == 0) stg[s] <= d;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mdm_status_track.sv
module mdm_status_track
  import mdm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  mdm_lines_t lvl_next,
  input  logic       clr,
  output mdm_lines_t lvl_q,
  output mdm_lines_t delta_q
);
  mdm_lines_t chg;

  for (genvar i = 0; i < LINES; i++) begin : g_edge
    if (i == IDX_RI) begin : g_fall
      assign chg[i] = lvl_q[i] & ~lvl_next[i];
    end else begin : g_any
      assign chg[i] = lvl_q[i] ^ lvl_next[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      delta_q <= '0;
    end else begin
      lvl_q   <= lvl_next;
      delta_q <= (clr ? '0 : delta_q) | chg;
    end
  end

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && lvl_next == lvl_q) |=> delta_q == '0);

  assert_ri_rise_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !delta_q[IDX_RI] && !lvl_q[IDX_RI] && lvl_next[IDX_RI]) |=> !delta_q[IDX_RI]);
endmodule

// File: rtl/mdm_loop_ctl.sv
module mdm_loop_ctl
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [7:0] ctrl_wdata,
  output logic [7:0] ctrl_rdata,
  input  logic       stat_rd,
  output logic [7:0] stat_rdata,
  input  logic       msi_en,
  input  logic       line_cts,
  input  logic       line_dsr,
  input  logic       line_ri,
  input  logic       line_dcd,
  output logic       line_dtr,
  output logic       line_rts,
  output logic       line_out1,
  output logic       line_out2,
  input  logic       ser_tx_in,
  output logic       ser_rx_out,
  output logic       pin_txd,
  input  logic       pin_rxd,
  output logic       irq_modem
);
  mdm_ctrl_t  ctrl_q;
  mdm_lines_t ext_raw, ext_sync, loop_src, lvl_next, lvl_q, delta_q;

  mdm_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(ctrl_wdata),
    .ctrl_q(ctrl_q), .rdata(ctrl_rdata)
  );

  assign ext_raw = {line_dcd, line_ri, line_dsr, line_cts};

  mdm_line_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_raw), .q(ext_sync)
  );

  assign loop_src = {ctrl_q.out2, ctrl_q.out1, ctrl_q.rts, ctrl_q.dtr};
  assign lvl_next = ctrl_q.loop ? loop_src : ext_sync;

  mdm_status_track u_track (
    .clk(clk), .rst_n(rst_n), .lvl_next(lvl_next), .clr(stat_rd),
    .lvl_q(lvl_q), .delta_q(delta_q)
  );

  assign stat_rdata = {lvl_q, delta_q};

  always_comb begin
    line_dtr  = ctrl_q.dtr  & ~ctrl_q.loop;
    line_rts  = ctrl_q.rts  & ~ctrl_q.loop;
    line_out1 = ctrl_q.out1 & ~ctrl_q.loop;
    line_out2 = ctrl_q.out2 & ~ctrl_q.loop;
    pin_txd    = ctrl_q.loop ? 1'b1 : ser_tx_in;
    ser_rx_out = ctrl_q.loop ? ser_tx_in : pin_rxd;
  end

  assign irq_modem = msi_en & ctrl_q.out2 & (|delta_q);

  assert_loop_pins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.loop |-> (pin_txd && ser_rx_out == ser_tx_in &&
                     !line_dtr && !line_rts && !line_out1 && !line_out2));

  assert_loop_levels_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.loop && $past(ctrl_q.loop)) |-> lvl_q == $past(loop_src));

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!msi_en || !ctrl_q.out2 || delta_q == '0) |-> !irq_modem);
endmodule

// File: tb/mdm_loop_ctl_tb.sv
module mdm_loop_ctl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_wr = 0, stat_rd = 0, msi_en = 0;
  logic [7:0] ctrl_wdata = 0;
  logic line_cts = 0, line_dsr = 0, line_ri = 0, line_dcd = 0;
  logic ser_tx_in = 1, pin_rxd = 1;
  logic [7:0] ctrl_rdata, stat_rdata;
  logic line_dtr, line_rts, line_out1, line_out2, ser_rx_out, pin_txd, irq_modem;
  int total = 0, bad = 0;
  logic [7:0] snap;

  always #5 clk = ~clk;

  mdm_loop_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .stat_rd(stat_rd), .stat_rdata(stat_rdata),
    .msi_en(msi_en), .line_cts(line_cts), .line_dsr(line_dsr), .line_ri(line_ri),
    .line_dcd(line_dcd), .line_dtr(line_dtr), .line_rts(line_rts),
    .line_out1(line_out1), .line_out2(line_out2), .ser_tx_in(ser_tx_in),
    .ser_rx_out(ser_rx_out), .pin_txd(pin_txd), .pin_rxd(pin_rxd),
    .irq_modem(irq_modem)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_wr = 1; ctrl_wdata = v;
    tick(1);
    ctrl_wr = 0;
  endtask

  task automatic rd_stat();
    stat_rd = 1; #1;
    snap = stat_rdata;
    tick(1);
    stat_rd = 0;
  endtask

  task automatic t_reset();
    chk("R1 reset ctrl", ctrl_rdata, 8'h00);
    chk("R3 reset stat", stat_rdata, 8'h00);
    chk("R10 reset irq", {7'b0, irq_modem}, 8'h00);
    chk("R9 reset txd", {7'b0, pin_txd}, 8'h01);
  endtask

  task automatic t_ctrl();
    wr_ctrl(8'hEF);
    chk("R1 readback", ctrl_rdata, 8'h0F);
    chk("R2 outputs", {4'b0, line_out2, line_out1, line_rts, line_dtr}, 8'h0F);
  endtask

  task automatic t_cts();
    msi_en = 1; line_cts = 1;
    tick(2);
    chk("R3 early", stat_rdata, 8'h00);
    tick(1);
    chk("R4 cts rise", stat_rdata, 8'h11);
    chk("R10 irq on", {7'b0, irq_modem}, 8'h01);
    rd_stat();
    chk("R6 read value", snap, 8'h11);
    chk("R6 cleared", stat_rdata, 8'h10);
    chk("R10 irq off", {7'b0, irq_modem}, 8'h00);
    tick(3);
    chk("R4 stays clear", stat_rdata, 8'h10);
  endtask

  task automatic t_ring();
    line_ri = 1; tick(3);
    chk("R5 ri rise", stat_rdata, 8'h50);
    line_ri = 0; tick(3);
    chk("R5 ri fall", stat_rdata, 8'h14);
    rd_stat();
    chk("R6 ri clear", stat_rdata, 8'h10);
  endtask

  task automatic t_pair_irq();
    line_dsr = 1; line_dcd = 1; msi_en = 0; tick(3);
    chk("R4 dsr dcd", stat_rdata, 8'hBA);
    chk("R10 msi off", {7'b0, irq_modem}, 8'h00);
    msi_en = 1; #1;
    chk("R10 msi on", {7'b0, irq_modem}, 8'h01);
    wr_ctrl(8'h07);
    chk("R10 out2 gate", {7'b0, irq_modem}, 8'h00);
    rd_stat();
    chk("R6 pair clear", stat_rdata, 8'hB0);
  endtask

  task automatic t_read_race();
    line_cts = 0; tick(2);
    rd_stat();
    chk("R7 pre value", snap, 8'hB0);
    chk("R7 reset flag", stat_rdata, 8'hA1);
    rd_stat();
    chk("R7 then clear", stat_rdata, 8'hA0);
  endtask

  task automatic t_loop();
    wr_ctrl(8'h15); tick(1);
    chk("R8 loop levels", stat_rdata, 8'h5B);
    chk("R9 outs idle", {4'b0, line_out2, line_out1, line_rts, line_dtr}, 8'h00);
    ser_tx_in = 0; pin_rxd = 1; #1;
    chk("R9 loop rx", {7'b0, ser_rx_out}, 8'h00);
    chk("R9 txd mark", {7'b0, pin_txd}, 8'h01);
    rd_stat();
    line_cts = 1; line_dsr = 0; line_ri = 1; line_dcd = 0; tick(4);
    chk("R8 ext ignored", stat_rdata, 8'h50);
    wr_ctrl(8'h11); tick(1);
    chk("R8 R5 loop ri fall", stat_rdata, 8'h14);
  endtask

  task automatic t_exit();
    wr_ctrl(8'h00);
    ser_tx_in = 0; pin_rxd = 1; #1;
    chk("R9 txd follows", {7'b0, pin_txd}, 8'h00);
    chk("R9 rx from pin", {7'b0, ser_rx_out}, 8'h01);
    pin_rxd = 0; ser_tx_in = 1; #1;
    chk("R9 rx from pin 0", {7'b0, ser_rx_out}, 8'h00);
    chk("R9 txd follows 1", {7'b0, pin_txd}, 8'h01);
  endtask

  initial begin
    fork
      begin
        tick(3);
        rst_n = 1;
        tick(1);
        t_reset();
        t_ctrl();
        t_cts();
        t_ring();
        t_pair_irq();
        t_read_race();
        t_loop();
        t_exit();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog got=hang exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule